// File: doc/BRIEF.md
# Bus Target Memory and I/O Data Responder

This block is the data-phase half of a parallel-bus target. Each time the initiator presents an address, it checks which address space the access belongs to: memory or I/O. It then compares the address against the matching programmed base. The access is claimed only when the enable for that space is set. A claimed access asserts the select response and then serves one or more data phases from a small word-wide store. Each address space has its own store.

Writes merge into the addressed word lane by lane under the byte enables. Reads return the addressed word one cycle after the data phase is accepted. A burst starts at any dword-aligned offset and advances by one dword per data phase. It ends in one of two ways:

- The initiator marks a phase as the last one.
- The block reaches the final dword of its window and signals a disconnect.

The memory window and the I/O window are both set by parameters, and each has its own base. The store behind each window is smaller than the window. Stored words repeat every `2^DEPTH_LG` dwords within a window.

Top module: `pci_tgt_resp`

## Requirements
- R1: After reset, `devsel`, `rvalid` and `disconnect` are low.
- R2: A memory request (`req_io`=0) claims when `cfg_mem_en`=1 and `req_addr[31:MEM_WIN]` equals `mem_base[31:MEM_WIN]`. With the default MEM_WIN=16 and base 0x10000, the window is 0x10000 to 0x1FFFF. `devsel` is high from the cycle after the request.
- R3: An I/O request (`req_io`=1) claims when `cfg_io_en`=1 and `req_addr[31:IO_WIN]` equals `io_base[31:IO_WIN]`. With the default IO_WIN=8 and base 0x100, the window is 0x100 to 0x1FF.
- R4: In each of the following cases `devsel` stays low, and data phases that follow leave both stores unchanged:
  - the address is outside the window;
  - the enable for the space is clear;
  - the request is for the other space.
- R5: A write data phase replaces byte lane k of the addressed word only where `be[k]`=1; lane k is bits 8k+7:8k. Example: 0xFFFFFFFF written with 0x78 under `be`=0x1 becomes 0xFFFFFF78.
- R6: A burst ignores `req_addr[1:0]` and starts at the addressed dword, including offsets that are not multiples of 8. Each accepted data phase (`dat_valid`=1) advances the address by 4 bytes. The stores are word-indexed by (address / 4) mod 2^DEPTH_LG.
- R7: For a read data phase, `rvalid` is high and `rdata` holds the addressed word in the following cycle. `rvalid` is low after write phases and idle cycles.
- R8: A data phase with `frame`=0 is the last of its burst, and `devsel` is low in the next cycle.
- R9: A data phase on the last dword of the window with `frame`=1 is still performed. In the next cycle, `disconnect` is high for one cycle and `devsel` is low.
- R10: The memory store and the I/O store are separate: a write in one space does not change words read from the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mem_en | input | 1 | Memory space enable |
| cfg_io_en | input | 1 | I/O space enable |
| mem_base | input | 32 | Memory window base (upper bits used) |
| io_base | input | 32 | I/O window base (upper bits used) |
| req_valid | input | 1 | Address phase strobe |
| req_addr | input | 32 | Byte address of the first data phase |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| dat_valid | input | 1 | Data phase strobe |
| frame | input | 1 | 1 = more phases follow this one |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte-lane enables, active high |
| devsel | output | 1 | Access claimed and burst in progress |
| rdata | output | 32 | Read data |
| rvalid | output | 1 | `rdata` valid for the previous read phase |
| disconnect | output | 1 | Burst stopped at the window end |

## Verification
The hardest case to reach is a disconnect at the window end. It only happens when a claimed burst reaches the final dword of the window while `frame` is still asserted. The bench therefore starts bursts a few dwords below the top of each window, at 0x1FFF8 for memory and 0x1F4 for I/O. It asks for more phases than fit, and checks that exactly the phases up to the boundary are performed. A second subtle case is storage aliasing: the last dwords of the memory window share store words with the bottom of the window. A bench model indexed the same way predicts every read word after these wrapped writes, after all sixteen byte-enable patterns, and after overlapping bursts.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [1:0] {
        SP_NONE = 2'd0,
        SP_MEM  = 2'd1,
        SP_IO   = 2'd2
    } space_e;

    // True when a and b agree in every bit at or above position win.
    function automatic logic window_hit(logic [DATA_W-1:0] a,
                                        logic [DATA_W-1:0] b,
                                        int win);
        logic [DATA_W-1:0] diff;
        diff = (a ^ b) >> win;
        return diff == '0;
    endfunction

    // Lane-wise merge of a new word into an old one under byte enables.
    function automatic logic [DATA_W-1:0] merge_lanes(logic [DATA_W-1:0] old_w,
                                                      logic [DATA_W-1:0] new_w,
                                                      logic [LANES-1:0]  lane_en);
        logic [DATA_W-1:0] r;
        for (int k = 0; k < LANES; k++) begin
            r[8*k +: 8] = lane_en[k] ? new_w[8*k +: 8] : old_w[8*k +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
    import pci_tgt_pkg::*;
#(
    parameter int MEM_WIN = 16,
    parameter int IO_WIN  = 8
) (
    input  logic [DATA_W-1:0] addr,
    input  logic              is_io,
    input  logic [DATA_W-1:0] mem_base,
    input  logic [DATA_W-1:0] io_base,
    input  logic              mem_en,
    input  logic              io_en,
    output space_e            hit
);

    logic mem_match;
    logic io_match;

    always_comb begin
        mem_match = window_hit(addr, mem_base, MEM_WIN);
        io_match  = window_hit(addr, io_base, IO_WIN);
        hit       = SP_NONE;
        if (is_io) begin
            if (io_en && io_match) hit = SP_IO;
        end else begin
            if (mem_en && mem_match) hit = SP_MEM;
        end
    end

endmodule

// File: rtl/pci_tgt_store.sv
module pci_tgt_store
    import pci_tgt_pkg::*;
#(
    parameter int DEPTH_LG = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic                re,
    input  logic [DEPTH_LG-1:0] idx,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [LANES-1:0]    lane_en,
    output logic [DATA_W-1:0]   rdata
);

    localparam int DEPTH = 1 << DEPTH_LG;

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words[idx] <= merge_lanes(words[idx], wdata, lane_en);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= words[idx];
        end
    end

endmodule

// File: rtl/pci_tgt_seq.sv
module pci_tgt_seq
    import pci_tgt_pkg::*;
#(
    parameter int MEM_WIN = 16,
    parameter int IO_WIN  = 8,
    parameter int OFF_W   = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  space_e           hit,
    input  logic             req_write,
    input  logic [OFF_W-1:0] req_off,
    input  logic             dat_valid,
    input  logic             frame,
    output logic [1:0]       we_sp,
    output logic [1:0]       re_sp,
    output logic [OFF_W-1:0] off,
    output logic             rd_sel_io,
    output logic             devsel,
    output logic             rvalid,
    output logic             disconnect
);

    typedef struct packed {
        logic             active;
        space_e           space;
        logic             write;
        logic [OFF_W-1:0] off;
    } burst_t;

    burst_t cur;
    logic   phase;
    logic   at_end;
    logic   last;

    always_comb begin
        phase  = cur.active && dat_valid;
        if (cur.space == SP_IO) at_end = &cur.off[IO_WIN-3:0];
        else                    at_end = &cur.off[MEM_WIN-3:0];
        last   = !frame || at_end;
        off    = cur.off;
        we_sp  = 2'b00;
        re_sp  = 2'b00;
        if (phase) begin
            if (cur.space == SP_IO) begin
                we_sp[1] = cur.write;
                re_sp[1] = !cur.write;
            end else begin
                we_sp[0] = cur.write;
                re_sp[0] = !cur.write;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur        <= '{active: 1'b0, space: SP_NONE, write: 1'b0, off: '0};
            rvalid     <= 1'b0;
            disconnect <= 1'b0;
            rd_sel_io  <= 1'b0;
        end else begin
            rvalid     <= phase && !cur.write;
            disconnect <= phase && at_end && frame;
            if (phase && !cur.write) rd_sel_io <= (cur.space == SP_IO);
            if (!cur.active) begin
                if (req_valid && hit != SP_NONE) begin
                    cur.active <= 1'b1;
                    cur.space  <= hit;
                    cur.write  <= req_write;
                    cur.off    <= req_off;
                end
            end else if (phase) begin
                if (last) begin
                    cur.active <= 1'b0;
                    cur.space  <= SP_NONE;
                end else begin
                    cur.off <= cur.off + 1'b1;
                end
            end
        end
    end

    assign devsel = cur.active;

endmodule

// File: rtl/pci_tgt_resp.sv
module pci_tgt_resp
    import pci_tgt_pkg::*;
#(
    parameter int MEM_WIN      = 16,
    parameter int IO_WIN       = 8,
    parameter int MEM_DEPTH_LG = 6,
    parameter int IO_DEPTH_LG  = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_mem_en,
    input  logic        cfg_io_en,
    input  logic [31:0] mem_base,
    input  logic [31:0] io_base,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    input  logic        req_io,
    input  logic        req_write,
    input  logic        dat_valid,
    input  logic        frame,
    input  logic [31:0] wdata,
    input  logic [3:0]  be,
    output logic        devsel,
    output logic [31:0] rdata,
    output logic        rvalid,
    output logic        disconnect
);

    localparam int OFF_W = ((MEM_WIN > IO_WIN) ? MEM_WIN : IO_WIN) - 2;

    space_e            hit;
    logic [OFF_W-1:0]  req_off;
    logic [OFF_W-1:0]  off;
    logic [1:0]        we_sp;
    logic [1:0]        re_sp;
    logic              rd_sel_io;
    logic [DATA_W-1:0] sp_rdata [2];

    always_comb begin
        req_off = '0;
        if (req_io) req_off[IO_WIN-3:0]  = req_addr[IO_WIN-1:2];
        else        req_off[MEM_WIN-3:0] = req_addr[MEM_WIN-1:2];
    end

    pci_tgt_decode #(.MEM_WIN(MEM_WIN), .IO_WIN(IO_WIN)) u_decode (
        .addr     (req_addr),
        .is_io    (req_io),
        .mem_base (mem_base),
        .io_base  (io_base),
        .mem_en   (cfg_mem_en),
        .io_en    (cfg_io_en),
        .hit      (hit)
    );

    pci_tgt_seq #(.MEM_WIN(MEM_WIN), .IO_WIN(IO_WIN), .OFF_W(OFF_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .hit        (hit),
        .req_write  (req_write),
        .req_off    (req_off),
        .dat_valid  (dat_valid),
        .frame      (frame),
        .we_sp      (we_sp),
        .re_sp      (re_sp),
        .off        (off),
        .rd_sel_io  (rd_sel_io),
        .devsel     (devsel),
        .rvalid     (rvalid),
        .disconnect (disconnect)
    );

    for (genvar g = 0; g < 2; g++) begin : g_space
        localparam int DL = (g == 0) ? MEM_DEPTH_LG : IO_DEPTH_LG;
        pci_tgt_store #(.DEPTH_LG(DL)) u_store (
            .clk     (clk),
            .rst     (rst),
            .we      (we_sp[g]),
            .re      (re_sp[g]),
            .idx     (off[DL-1:0]),
            .wdata   (wdata),
            .lane_en (be),
            .rdata   (sp_rdata[g])
        );
    end

    assign rdata = rd_sel_io ? sp_rdata[1] : sp_rdata[0];

endmodule

// File: rtl/pci_tgt_resp_chk.sv
module pci_tgt_resp_chk (
    input logic clk,
    input logic rst,
    input logic cfg_mem_en,
    input logic cfg_io_en,
    input logic req_valid,
    input logic dat_valid,
    input logic frame,
    input logic devsel,
    input logic rvalid,
    input logic disconnect
);

    // R2
    claim_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(devsel) |-> $past(req_valid));

    // R4
    no_claim_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_mem_en && !cfg_io_en && !devsel) |=> !devsel);

    // R7
    rvalid_after_phase_chk: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> ($past(devsel) && $past(dat_valid)));

    // R8
    last_phase_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (devsel && dat_valid && !frame) |=> !devsel);

    // R8
    drop_needs_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(devsel) |-> $past(dat_valid));

    // R9
    disconnect_shape_chk: assert property (@(posedge clk) disable iff (rst)
        disconnect |-> (!devsel && $past(frame) && $past(devsel)));

endmodule

bind pci_tgt_resp pci_tgt_resp_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_mem_en (cfg_mem_en),
    .cfg_io_en  (cfg_io_en),
    .req_valid  (req_valid),
    .dat_valid  (dat_valid),
    .frame      (frame),
    .devsel     (devsel),
    .rvalid     (rvalid),
    .disconnect (disconnect)
);

// File: tb/test_pci_tgt_resp.sv
`timescale 1ns/1ps
module test_pci_tgt_resp;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_mem_en = 1'b0;
    logic        cfg_io_en = 1'b0;
    logic [31:0] mem_base = 32'h0001_0000;
    logic [31:0] io_base = 32'h0000_0100;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_io = 1'b0;
    logic        req_write = 1'b0;
    logic        dat_valid = 1'b0;
    logic        frame = 1'b0;
    logic [31:0] wdata = '0;
    logic [3:0]  be = 4'hF;
    logic        devsel;
    logic [31:0] rdata;
    logic        rvalid;
    logic        disconnect;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] ref_mem [64];
    logic [31:0] ref_io  [64];

    always #2 clk = ~clk;

    pci_tgt_resp i_pci_tgt_resp (
        .clk(clk), .rst(rst), .cfg_mem_en(cfg_mem_en), .cfg_io_en(cfg_io_en),
        .mem_base(mem_base), .io_base(io_base), .req_valid(req_valid),
        .req_addr(req_addr), .req_io(req_io), .req_write(req_write),
        .dat_valid(dat_valid), .frame(frame), .wdata(wdata), .be(be),
        .devsel(devsel), .rdata(rdata), .rvalid(rvalid), .disconnect(disconnect)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mrg(logic [31:0] o, logic [31:0] n, logic [3:0] e);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) r[8*k +: 8] = e[k] ? n[8*k +: 8] : o[8*k +: 8];
        return r;
    endfunction

    // One access: address phase, then up to n data phases.
    task automatic burst(input logic [31:0] a, input bit io, input bit wr, input int n,
                         input logic [31:0] seed, input logic [3:0] e, input bit claim,
                         input string tag);
        logic [31:0] cur;
        int win;
        int idx;
        bit at_end;
        bit lst;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_io = io; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " claim"}, {31'd0, devsel}, {31'd0, claim});
        if (!claim) begin
            dat_valid = 1'b1; frame = 1'b0; wdata = seed; be = e;
            @(negedge clk);
            dat_valid = 1'b0;
            chk({tag, " R4 still idle"}, {31'd0, devsel}, 32'd0);
            return;
        end
        win = io ? 256 : 65536;
        cur = a & ~32'd3;
        for (int i = 0; i < n; i++) begin
            at_end = ((cur % win) == (win - 4));
            lst = (i == n - 1) || at_end;
            dat_valid = 1'b1; frame = (i != n - 1);
            wdata = seed ^ (i * 32'h1111_1111); be = e;
            idx = (cur >> 2) & 63;
            @(negedge clk);
            if (wr) begin
                if (io) ref_io[idx] = mrg(ref_io[idx], wdata, e);
                else    ref_mem[idx] = mrg(ref_mem[idx], wdata, e);
                chk({tag, " R7 no rvalid on write"}, {31'd0, rvalid}, 32'd0);
            end else begin
                chk({tag, " R7 rvalid"}, {31'd0, rvalid}, 32'd1);
                chk({tag, " R6 R10 rdata"}, rdata, io ? ref_io[idx] : ref_mem[idx]);
            end
            chk({tag, " R8 devsel"}, {31'd0, devsel}, {31'd0, !lst});
            chk({tag, " R9 disconnect"}, {31'd0, disconnect}, {31'd0, at_end && (i != n - 1)});
            if (lst) break;
            cur = cur + 4;
        end
        dat_valid = 1'b0; frame = 1'b0;
        @(negedge clk);
        chk({tag, " R7 rvalid idle"}, {31'd0, rvalid}, 32'd0);
        chk({tag, " R9 disconnect single"}, {31'd0, disconnect}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin ref_mem[i] = '0; ref_io[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 devsel", {31'd0, devsel}, 32'd0);
        chk("R1 rvalid", {31'd0, rvalid}, 32'd0);
        chk("R1 disconnect", {31'd0, disconnect}, 32'd0);
        cfg_mem_en = 1'b1; cfg_io_en = 1'b1;

        // Fill both stores with full words.
        burst(32'h0001_0000, 1'b0, 1'b1, 64, 32'hA5A5_0000, 4'hF, 1'b1, "R2 fill");
        burst(32'h0000_0100, 1'b1, 1'b1, 64, 32'h5A5A_0000, 4'hF, 1'b1, "R3 fill");

        // Byte-lane sweep over all enable patterns, both spaces.
        for (int e = 0; e < 16; e++) begin
            burst(32'h0000_0100, 1'b1, 1'b1, 1, 32'hFFFF_FFFF, 4'hF, 1'b1, "R5 io pre");
            burst(32'h0000_0100, 1'b1, 1'b1, 1, 32'h1234_5678 + e, e[3:0], 1'b1, "R5 io wr");
            burst(32'h0000_0100, 1'b1, 1'b0, 1, 0, 4'h0, 1'b1, "R5 io rd");
            burst(32'h0001_0000, 1'b0, 1'b1, 1, 32'hFFFF_FFFF, 4'hF, 1'b1, "R5 mem pre");
            burst(32'h0001_0000, 1'b0, 1'b1, 1, 32'h8765_4321 - e, e[3:0], 1'b1, "R5 mem wr");
            burst(32'h0001_0000, 1'b0, 1'b0, 1, 0, 4'h0, 1'b1, "R5 mem rd");
        end
        // Named example: 0xFFFFFFFF merged with 0x78 under lane 0.
        burst(32'h0001_0000, 1'b0, 1'b1, 1, 32'hFFFF_FFFF, 4'hF, 1'b1, "R5 ex pre");
        burst(32'h0001_0000, 1'b0, 1'b1, 1, 32'h0000_0078, 4'h1, 1'b1, "R5 ex wr");
        burst(32'h0001_0000, 1'b0, 1'b0, 1, 0, 4'h0, 1'b1, "R5 ex rd");
        chk("R5 example word", ref_mem[0], 32'hFFFF_FF78);

        // Bursts from several dword starts and lengths, then overlapping reads.
        for (int s = 1; s < 5; s++) begin
            for (int n = 1; n < 7; n++) begin
                burst(32'h0001_0000 + 4*s + 8*n, 1'b0, 1'b1, n, 32'hC000_0000 + 256*s + n,
                      4'hF, 1'b1, "R6 mem wr");
            end
            burst(32'h0001_0000 + 4*s + 1, 1'b0, 1'b0, 12, 0, 4'h0, 1'b1, "R6 mem rd");
            burst(32'h0000_0100 + 4*s + 2, 1'b1, 1'b1, s + 2, 32'h3300_0000 + s, 4'hF, 1'b1,
                  "R6 io wr");
            burst(32'h0000_0100, 1'b1, 1'b0, 10, 0, 4'h0, 1'b1, "R10 io rd");
            burst(32'h0001_0000, 1'b0, 1'b0, 10, 0, 4'h0, 1'b1, "R10 mem rd");
        end

        // Window-end disconnects.
        burst(32'h0001_FFF8, 1'b0, 1'b1, 4, 32'hDDDD_0000, 4'hF, 1'b1, "R9 mem wr");
        burst(32'h0001_FFF0, 1'b0, 1'b0, 6, 0, 4'h0, 1'b1, "R9 mem rd");
        burst(32'h0000_01F4, 1'b1, 1'b0, 5, 0, 4'h0, 1'b1, "R9 io rd");
        burst(32'h0001_FFFC, 1'b0, 1'b0, 1, 0, 4'h0, 1'b1, "R9 last frame low");

        // No-claim cases; the data phase must not disturb the stores.
        burst(32'h0002_0000, 1'b0, 1'b1, 1, 32'hBAD0_0001, 4'hF, 1'b0, "R4 mem miss");
        burst(32'h0000_0200, 1'b1, 1'b1, 1, 32'hBAD0_0002, 4'hF, 1'b0, "R4 io miss");
        burst(32'h0001_0000, 1'b1, 1'b1, 1, 32'hBAD0_0003, 4'hF, 1'b0, "R4 wrong space io");
        burst(32'h0000_0100, 1'b0, 1'b1, 1, 32'hBAD0_0004, 4'hF, 1'b0, "R4 wrong space mem");
        cfg_mem_en = 1'b0;
        burst(32'h0001_0000, 1'b0, 1'b1, 1, 32'hBAD0_0005, 4'hF, 1'b0, "R4 mem disabled");
        burst(32'h0000_0104, 1'b1, 1'b0, 1, 0, 4'h0, 1'b1, "R3 io while mem off");
        cfg_mem_en = 1'b1; cfg_io_en = 1'b0;
        burst(32'h0000_0100, 1'b1, 1'b1, 1, 32'hBAD0_0006, 4'hF, 1'b0, "R4 io disabled");
        cfg_io_en = 1'b1;
        burst(32'h0001_0000, 1'b0, 1'b0, 64, 0, 4'h0, 1'b1, "R4 mem intact");
        burst(32'h0000_0100, 1'b1, 1'b0, 64, 0, 4'h0, 1'b1, "R4 io intact");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule